// File: doc/BRIEF.md
# Integer Divide and Modulo Unit

This block is the iterative integer divider of a processor execution pipeline. It takes two operands and a small operation selector, then returns either the quotient or the remainder together with an overflow flag. It handles full-width and half-width (word) operands, signed and unsigned arithmetic, and an extended-dividend form. In the extended form the first operand is shifted up by the operand width and divided by the zero-extended second operand. Internally it runs a restoring shift-and-subtract loop on magnitudes and retires one quotient bit per clock. A word operation takes half as many steps as a full-width one.

The caller raises `start` for one cycle while `busy` is low. `busy` stays high while the loop runs. `done` pulses for one cycle when `result` and `overflow` are updated, and both outputs hold their values until the next `done`. Any overflow condition that can be seen from the operands alone finishes at once, with a zero result. The extended signed range check happens after the loop and also forces a zero result.

Top module: `idiv_unit`

## Requirements
- R1: Unsigned quotient: with `op_signed`=0, `op_mod`=0 and `op_ext`=0, the result is floor(a/b) over the active width, where the active width is XLEN bits, or XLEN/2 bits when `op_word`=1.
- R2: Signed quotient: with `op_signed`=1, operands are two's complement over the active width and the quotient truncates toward zero (for example -7/2 = -3).
- R3: Modulo: with `op_mod`=1 the result is the remainder. In signed mode the remainder takes the sign of the dividend (for example -7 mod 2 = -1, 7 mod -2 = 1).
- R4: A divisor that is zero over the active width reports overflow in every form.
- R5: In signed non-extended divide and modulo, a dividend equal to the most negative value combined with a divisor of all ones reports overflow.
- R6: With `op_word`=1, only bits [XLEN/2-1:0] of each operand are used, and result bits [XLEN-1:XLEN/2] are zero.
- R7: Unsigned extended (`op_ext`=1, `op_mod`=0): the dividend is a·2^W and the divisor is b zero-extended, where W is the active width. The operation succeeds only when a < b (unsigned). Otherwise it reports overflow.
- R8: Signed extended: the dividend is signed a·2^W and the divisor is the unsigned value b. When |a| >= b it reports overflow at once. Otherwise it reports overflow if the quotient lies outside [-2^(W-1), 2^(W-1)-1].
- R9: Whenever `overflow`=1 at `done`, `result` is all zeros. An overflow found from the operands alone (R4, R5, R7, the |a|>=b case of R8) raises `done` at the same rising edge that samples `start`, and `busy` never rises.
- R10: A non-overflow-at-start operation raises `done` at the W+1th rising edge after the edge that samples `start`. `busy` is high in between, `done` is a one-cycle pulse, and `result`/`overflow` change only together with `done`.
- R11: A `start` applied while `busy`=1 is ignored: it causes no extra `done` and does not disturb the running result.
- R12: When `op_mod`=1, `op_ext` has no effect, and the plain modulo result is returned.
- R13: After reset, `busy`, `done`, `overflow` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when not busy) |
| op_word | input | 1 | 1: half-width operands and result |
| op_signed | input | 1 | 1: two's complement arithmetic |
| op_mod | input | 1 | 1: return remainder instead of quotient |
| op_ext | input | 1 | 1: extended dividend (first operand shifted up by width) |
| opa | input | XLEN | Dividend operand |
| opb | input | XLEN | Divisor operand |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: result and overflow updated |
| result | output | XLEN | Quotient or remainder, zero on overflow |
| overflow | output | 1 | Operation overflowed |

## Verification
A step counter that is loaded or decremented wrongly shows up at once at the ports. `done` then arrives at the wrong edge, which the scoreboard measures against the expected W+1 latency, and the truncated loop also yields a wrong quotient. A sign flag that is latched wrongly, or a remainder register that is corrupted, only shows when `done` rises. It appears there as a result whose sign or magnitude differs from the bench's wide-integer reference. A fault in the overflow path shows in the cycle after `start`, either as a missing early `done` or as a nonzero result beside `overflow`=1.

// File: rtl/idiv_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the iterative divider.
// Assumes: nothing beyond IEEE 1800-2017.
package idiv_pkg;

    // Operation selector as latched at start
    typedef struct packed {
        logic word;
        logic sgn;
        logic modop;
        logic ext;
    } idiv_op_t;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } idiv_state_t;

endpackage

// File: rtl/idiv_prep.sv
`timescale 1ns/1ps
// Module: idiv_prep
// Turns raw operands and the operation selector into magnitudes, initial
// loop values, result sign flags, the step count and the early overflow.
// Assumes: XLEN is even; purely combinational.
module idiv_prep
    import idiv_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2,
    localparam int CW = $clog2(XLEN + 1)
) (
    input  idiv_op_t          op,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic [XLEN-1:0]   rem_init,
    output logic [XLEN-1:0]   quo_init,
    output logic [XLEN-1:0]   dvsr,
    output logic [CW-1:0]     steps,
    output logic              q_neg,
    output logic              r_neg,
    output logic              early_ovf
);

    logic [XLEN-1:0] lowmask, a_n, b_n, a_mag, b_mag, minval;
    logic            ext_eff, a_neg, b_neg;

    // Operand decoding, magnitude extraction and early overflow detection
    always_comb begin
        lowmask = op.word ? {{HALF{1'b0}}, {HALF{1'b1}}} : {XLEN{1'b1}};
        a_n     = opa & lowmask;
        b_n     = opb & lowmask;
        ext_eff = op.ext & ~op.modop;
        a_neg   = op.sgn & (op.word ? opa[HALF-1] : opa[XLEN-1]);
        b_neg   = op.sgn & ~ext_eff & (op.word ? opb[HALF-1] : opb[XLEN-1]);
        a_mag   = a_neg ? ((~a_n + 1'b1) & lowmask) : a_n;
        b_mag   = b_neg ? ((~b_n + 1'b1) & lowmask) : b_n;
        minval  = op.word ? (XLEN'(1) << (HALF - 1)) : (XLEN'(1) << (XLEN - 1));

        early_ovf = (b_n == '0)
                  | (op.sgn & ~ext_eff & (a_n == minval) & (b_n == lowmask))
                  | (ext_eff & (a_mag >= b_mag));

        rem_init = ext_eff ? a_mag : '0;
        quo_init = ext_eff ? '0 : (op.word ? (a_mag << HALF) : a_mag);
        dvsr     = b_mag;
        steps    = op.word ? CW'(HALF) : CW'(XLEN);
        q_neg    = ext_eff ? a_neg : (a_neg ^ b_neg);
        r_neg    = a_neg;
    end

endmodule

// File: rtl/idiv_step.sv
`timescale 1ns/1ps
// Module: idiv_step
// One restoring division step: shift the next dividend bit into the partial
// remainder, subtract the divisor when it fits, shift the quotient bit in.
// Assumes: rem < dvsr on entry, so the new remainder fits in XLEN bits.
module idiv_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] dvsr,
    output logic [XLEN-1:0] rem_nxt,
    output logic [XLEN-1:0] quo_nxt
);

    logic [XLEN:0] part;
    logic          take;

    // Trial subtraction and restore
    always_comb begin
        part    = {rem, quo[XLEN-1]};
        take    = (part >= {1'b0, dvsr});
        rem_nxt = take ? (part[XLEN-1:0] - dvsr) : part[XLEN-1:0];
        quo_nxt = {quo[XLEN-2:0], take};
    end

endmodule

// File: rtl/idiv_post.sv
`timescale 1ns/1ps
// Module: idiv_post
// Picks quotient or remainder, applies the result sign, masks to the active
// width and performs the extended signed range check.
// Assumes: quo/rem hold the finished magnitude results; combinational.
module idiv_post #(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] rem,
    input  logic [XLEN-1:0] quo,
    input  logic            word,
    input  logic            modop,
    input  logic            q_neg,
    input  logic            r_neg,
    input  logic            chk_range,
    output logic [XLEN-1:0] res,
    output logic            late_ovf
);

    logic [XLEN-1:0] lowmask, q_mag, val, sval, lim;
    logic            neg;

    // Sign fix-up, width masking and range check
    always_comb begin
        lowmask  = word ? {{HALF{1'b0}}, {HALF{1'b1}}} : {XLEN{1'b1}};
        q_mag    = quo & lowmask;
        val      = modop ? rem : q_mag;
        neg      = modop ? r_neg : q_neg;
        sval     = neg ? (~val + 1'b1) : val;
        lim      = word ? (XLEN'(1) << (HALF - 1)) : (XLEN'(1) << (XLEN - 1));
        late_ovf = chk_range & (q_neg ? (q_mag > lim) : (q_mag >= lim));
        res      = late_ovf ? '0 : (sval & lowmask);
    end

endmodule

// File: rtl/idiv_unit.sv
`timescale 1ns/1ps
// Module: idiv_unit (top)
// Iterative divide/modulo unit with start/busy/done handshake. Early
// overflow finishes in one cycle; otherwise W loop cycles plus one finish
// cycle, W being the active operand width.
// Assumes: start is only honoured while idle; outputs hold between dones.
module idiv_unit
    import idiv_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_word,
    input  logic            op_signed,
    input  logic            op_mod,
    input  logic            op_ext,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            overflow
);

    localparam int CW = $clog2(XLEN + 1);

    idiv_state_t     state;
    idiv_op_t        op_in, op_q;
    logic [CW-1:0]   cnt, steps;
    logic [XLEN-1:0] rem_q, quo_q, dvsr_q;
    logic [XLEN-1:0] rem_init, quo_init, dvsr_init, rem_nxt, quo_nxt, post_res;
    logic            q_neg_q, r_neg_q, q_neg_i, r_neg_i, early_ovf, late_ovf;

    // Gather the operation selector
    always_comb begin
        op_in = '{word: op_word, sgn: op_signed, modop: op_mod, ext: op_ext};
    end

    idiv_prep #(.XLEN(XLEN)) u_prep (
        .op        (op_in),
        .opa       (opa),
        .opb       (opb),
        .rem_init  (rem_init),
        .quo_init  (quo_init),
        .dvsr      (dvsr_init),
        .steps     (steps),
        .q_neg     (q_neg_i),
        .r_neg     (r_neg_i),
        .early_ovf (early_ovf)
    );

    idiv_step #(.XLEN(XLEN)) u_step (
        .rem     (rem_q),
        .quo     (quo_q),
        .dvsr    (dvsr_q),
        .rem_nxt (rem_nxt),
        .quo_nxt (quo_nxt)
    );

    idiv_post #(.XLEN(XLEN)) u_post (
        .rem       (rem_q),
        .quo       (quo_q),
        .word      (op_q.word),
        .modop     (op_q.modop),
        .q_neg     (q_neg_q),
        .r_neg     (r_neg_q),
        .chk_range (op_q.sgn & op_q.ext & ~op_q.modop),
        .res       (post_res),
        .late_ovf  (late_ovf)
    );

    // Busy whenever the sequencer is away from idle
    always_comb begin
        busy = (state != ST_IDLE);
    end

    // Sequencer, loop registers and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= '0;
            cnt      <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            dvsr_q   <= '0;
            q_neg_q  <= 1'b0;
            r_neg_q  <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
            overflow <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q <= op_in;
                        if (early_ovf) begin
                            done     <= 1'b1;
                            result   <= '0;
                            overflow <= 1'b1;
                        end else begin
                            rem_q   <= rem_init;
                            quo_q   <= quo_init;
                            dvsr_q  <= dvsr_init;
                            cnt     <= steps;
                            q_neg_q <= q_neg_i;
                            r_neg_q <= r_neg_i;
                            state   <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nxt;
                    quo_q <= quo_nxt;
                    cnt   <= cnt - 1'b1;
                    if (cnt == CW'(1)) begin
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done     <= 1'b1;
                    result   <= post_res;
                    overflow <= late_ovf;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/idiv_unit_chk.sv
`timescale 1ns/1ps
// Module: idiv_unit_chk
// Protocol and result checker for idiv_unit, attached by bind.
// Assumes: op_word_q is the word flag latched for the current operation.
module idiv_unit_chk #(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2,
    localparam int CW = $clog2(XLEN + 3)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            overflow,
    input logic [XLEN-1:0] result,
    input logic [XLEN-1:0] opb,
    input logic            op_word_q
);

    logic [CW-1:0] run_len;

    // Count consecutive busy cycles for the latency window
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else run_len <= '0;
    end

    // R9: overflow always comes with a zero result
    p_ovf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && overflow |-> result == '0);

    // R4 / R9: zero divisor finishes on the next cycle with overflow
    p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (opb == '0) |=> done && overflow && !busy);

    // R10: done is a single-cycle pulse and never overlaps busy
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: busy only ends with done
    p_busy_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> busy || done);

    // R10: outputs only move with done
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result) && $stable(overflow));

    // R10: an iterated operation spends W+1 busy cycles
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(busy) |-> run_len == (op_word_q ? CW'(HALF + 1) : CW'(XLEN + 1)));

    // R6: word results have a zero upper half
    p_word_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && op_word_q |-> result[XLEN-1:HALF] == '0);

endmodule

bind idiv_unit idiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .overflow  (overflow),
    .result    (result),
    .opb       (opb),
    .op_word_q (op_q.word)
);

// File: tb/idiv_unit_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for idiv_unit: the driver pushes expected items, the
// monitor pops and compares them whenever done pulses.
module idiv_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_word = 1'b0, op_signed = 1'b0, op_mod = 1'b0, op_ext = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic        busy, done, overflow;
    logic [63:0] result;

    int     n_checks = 0;
    int     n_fail = 0;
    longint cyc = 0;

    logic [63:0] q_res[$];
    logic        q_ovf[$];
    longint      q_due[$];
    string       q_tag[$];

    idiv_unit #(.XLEN(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_word(op_word), .op_signed(op_signed), .op_mod(op_mod), .op_ext(op_ext),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .result(result), .overflow(overflow)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model: returns {early, ovf, result}
    function automatic logic [65:0] ref_model(input bit w, input bit s, input bit m,
                                              input bit e, input logic [63:0] a,
                                              input logic [63:0] b);
        int n;
        logic [63:0] mask, an, bn, amag, res;
        logic signed [127:0] sa, sb, q, r, lim;
        logic [127:0] uq;
        bit ovf, early;
        n    = w ? 32 : 64;
        mask = w ? 64'h0000_0000_FFFF_FFFF : '1;
        an   = a & mask;
        bn   = b & mask;
        sa   = w ? {{96{a[31]}}, a[31:0]} : {{64{a[63]}}, a};
        sb   = w ? {{96{b[31]}}, b[31:0]} : {{64{b[63]}}, b};
        ovf = 0; early = 0; res = '0;
        if (bn == '0) begin
            ovf = 1; early = 1;
        end else if (m || !e) begin
            if (s) begin
                if ((w && an == 64'h8000_0000 && bn == mask) ||
                    (!w && an == 64'h8000_0000_0000_0000 && bn == mask)) begin
                    ovf = 1; early = 1;
                end else begin
                    q = sa / sb;
                    r = sa % sb;
                    res = (m ? r[63:0] : q[63:0]) & mask;
                end
            end else begin
                res = (m ? (an % bn) : (an / bn)) & mask;
            end
        end else if (!s) begin
            if (an >= bn) begin
                ovf = 1; early = 1;
            end else begin
                uq  = ({64'h0, an} << n) / {64'h0, bn};
                res = uq[63:0] & mask;
            end
        end else begin
            amag = sa[127] ? ((~an + 1) & mask) : an;
            if (amag >= bn) begin
                ovf = 1; early = 1;
            end else begin
                q   = (sa <<< n) / $signed({64'h0, bn});
                lim = 128'sd1 <<< (n - 1);
                if (q >= lim || q < -lim) ovf = 1;
                else res = q[63:0] & mask;
            end
        end
        if (ovf) res = '0;
        return {early, ovf, res};
    endfunction

    // Driver: wait for idle, apply one start pulse, push the expectation
    task automatic issue(input string tag, input bit w, input bit s, input bit m,
                         input bit e, input logic [63:0] a, input logic [63:0] b);
        logic [65:0] exp;
        while (q_res.size() != 0 || busy) @(negedge clk);
        exp = ref_model(w, s, m, e, a, b);
        @(negedge clk);
        op_word = w; op_signed = s; op_mod = m; op_ext = e; opa = a; opb = b;
        start = 1'b1;
        q_res.push_back(exp[63:0]);
        q_ovf.push_back(exp[64]);
        q_due.push_back(cyc + 1 + (exp[65] ? 0 : (w ? 33 : 65)));
        q_tag.push_back(tag);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compare each done against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_res.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 64'd1, 64'd0);
            end else begin
                logic [63:0] er;
                logic        eo;
                longint      ed;
                string       et;
                er = q_res.pop_front();
                eo = q_ovf.pop_front();
                ed = q_due.pop_front();
                et = q_tag.pop_front();
                check(result === er, et, "result", result, er);
                check(overflow === eo, et, "overflow", {63'd0, overflow}, {63'd0, eo});
                check(cyc == ed, "R10", "done cycle", cyc, ed);
                check(!busy, "R10", "busy at done", {63'd0, busy}, 64'd0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog cycles", cyc, 64'd150000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(busy == 0 && done == 0, "R13", "busy/done after reset", {62'd0, busy, done}, 64'd0);
        check(result == '0 && overflow == 0, "R13", "result/overflow after reset", result, 64'd0);

        // R1 unsigned quotient
        issue("R1", 0, 0, 0, 0, 64'd100, 64'd7);
        issue("R1", 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
        issue("R1", 0, 0, 0, 0, 64'd5, 64'd9);
        // R2 signed quotient truncation
        issue("R2", 0, 1, 0, 0, -64'sd7, 64'd2);
        issue("R2", 0, 1, 0, 0, 64'd7, -64'sd2);
        issue("R2", 0, 1, 0, 0, -64'sd7, -64'sd2);
        issue("R2", 0, 1, 0, 0, 64'h8000_0000_0000_0000, 64'd1);
        // R3 modulo with dividend sign
        issue("R3", 0, 1, 1, 0, -64'sd7, 64'd2);
        issue("R3", 0, 1, 1, 0, 64'd7, -64'sd2);
        issue("R3", 0, 0, 1, 0, 64'd1000, 64'd33);
        issue("R3", 1, 1, 1, 0, 64'h0000_0000_FFFF_FFF9, 64'd4);
        // R4 zero divisor, all forms
        issue("R4", 0, 0, 0, 0, 64'd5, 64'd0);
        issue("R4", 0, 1, 1, 0, 64'd5, 64'd0);
        issue("R4", 1, 1, 0, 1, 64'd5, 64'hABCD_0000_0000_0000);
        issue("R4", 0, 0, 0, 1, 64'd0, 64'd0);
        // R5 most negative by minus one
        issue("R5", 0, 1, 0, 0, 64'h8000_0000_0000_0000, '1);
        issue("R5", 1, 1, 1, 0, 64'h1234_5678_8000_0000, 64'h0000_0000_FFFF_FFFF);
        issue("R5", 1, 1, 0, 0, 64'h0000_0000_8000_0000, '1);
        // R6 word forms ignore upper halves
        issue("R6", 1, 0, 0, 0, 64'hDEAD_BEEF_0000_0064, 64'hFFFF_0000_0000_0007);
        issue("R6", 1, 1, 0, 0, 64'h1111_1111_FFFF_FFF9, 64'h2222_2222_0000_0002);
        // R7 unsigned extended
        issue("R7", 0, 0, 0, 1, 64'd1, 64'd2);
        issue("R7", 0, 0, 0, 1, 64'd7, 64'd7);
        issue("R7", 1, 0, 0, 1, 64'd3, 64'd10);
        // R8 signed extended
        issue("R8", 0, 1, 0, 1, -64'sd1, 64'd2);
        issue("R8", 0, 1, 0, 1, 64'd1, 64'd2);
        issue("R8", 0, 1, 0, 1, -64'sd2, 64'd2);
        issue("R8", 1, 1, 0, 1, 64'd3, 64'd10);
        issue("R8", 1, 1, 0, 1, 64'h0000_0000_FFFF_FFFD, 64'd100);
        // R12 ext ignored with modulo
        issue("R12", 0, 0, 1, 1, 64'd100, 64'd7);
        issue("R12", 0, 1, 1, 1, -64'sd100, 64'd7);

        // R11 start while busy is ignored
        issue("R11", 0, 0, 0, 0, 64'd123456789, 64'd1000);
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R11", "busy before stray start", {63'd0, busy}, 64'd1);
        opa = 64'd1; opb = 64'd0; op_word = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // Random mix (R1 R2 R3 R6 R7 R8)
        for (int i = 0; i < 160; i++) begin
            logic [63:0] a, b;
            logic [3:0]  o;
            o = 4'($urandom);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 3 == 0) b = b >> ($urandom % 60);
            if (i % 5 == 0) a = a >> ($urandom % 60);
            issue("RND", o[0], o[1], o[2], o[3], a, b);
        end

        while (q_res.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(q_res.size() == 0, "R11", "scoreboard drained", 64'(q_res.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule